// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is a 64-bit two-operand integer adder whose carry chain can be cut at run time. A two-bit mode input chooses between one 64-bit add, two independent 32-bit adds, four independent 16-bit adds or eight independent 8-bit adds. In every mode the same add is applied to all lanes in one operation. The datapath is one chain of 8-bit segment adders. A small decode table forces the carry into a segment to zero whenever that segment starts a lane in the selected mode.

Each lane wraps modulo two to the power of its width. Overflow never spills into the next lane. A per-byte carry-out vector is provided. In any mode, only the bits at the top byte of each lane are meaningful. The packed sum and the carry vector pass through an output stage that is a register by default, giving a latency of one cycle.

Top module: `simd_add`

## Requirements
- R1: `mode_i` selects the lane layout: 2'b00 is one 64-bit lane, 2'b01 is two 32-bit lanes, 2'b10 is four 16-bit lanes and 2'b11 is eight 8-bit lanes. Lane n always occupies bits [n*w+w-1 : n*w] for lane width w.
- R2: In mode 2'b00, `sum_o` equals (a + b) mod 2^64.
- R3: In mode 2'b01, each 32-bit lane of `sum_o` equals the matching lanes of `a_i` and `b_i` added modulo 2^32.
- R4: In mode 2'b10, each 16-bit lane of `sum_o` equals the matching lanes added modulo 2^16.
- R5: In mode 2'b11, each byte of `sum_o` equals the matching bytes added modulo 2^8.
- R6: No carry crosses a lane boundary. A lane that overflows (for example, all-ones plus one) leaves the lane above it exactly equal to that lane's own sum.
- R7: `cout_o[k]` at the top byte k of each lane (k = 7 for 1x64; k = 3 and 7 for 2x32; k = 1, 3, 5 and 7 for 4x16; every k for 8x8) is the carry out of that lane's add.
- R8: With the default output register, `sum_o` and `cout_o` show the result of the inputs present at a rising clock edge from that edge until the next one. While `rst_ni` is low, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Lane layout select |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| sum_o | output | 64 | Packed lane sums |
| cout_o | output | 8 | Carry out of each byte segment |

## Verification
Lane wrap-around and carry isolation at the boundary fall in the same cycle whenever a lane overflows. The bench provokes this with all-ones operands plus a one in each lane's low byte, and with sign-bit-heavy patterns. It judges the result by checking that each neighbouring lane holds only its own sum and that the lane-top carry bits are set. A per-lane reference model repeats the same judgement for random operands in all four modes.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int unsigned SEG_W = 8;

  typedef enum logic [1:0] {
    MODE_W64 = 2'b00,
    MODE_W32 = 2'b01,
    MODE_W16 = 2'b10,
    MODE_W8  = 2'b11
  } simd_mode_e;
endpackage

// File: rtl/simd_lane_cut.sv
module simd_lane_cut
  import simd_add_pkg::*;
#(
  parameter int unsigned NSEG = 8
) (
  input  simd_mode_e      mode_i,
  output logic [NSEG-1:0] cut_o
);
  // per segment, per mode: does this segment open a lane
  logic [3:0] tbl [NSEG];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    for (genvar m = 0; m < 4; m++) begin : g_mode
      assign tbl[k][m] = ((k % (NSEG >> m)) == 0);
    end
    assign cut_o[k] = tbl[k][mode_i];
  end

  always_comb begin
    assert_lane_count_R1: assert ($countones(cut_o) == (1 << mode_i))
      else $error("lane start count mismatch");
    if (mode_i == MODE_W8) begin
      assert_all_cut_R6: assert (&cut_o) else $error("byte lanes not all cut");
    end
  end
endmodule

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int unsigned W  = 72,
  parameter bit          EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/simd_add.sv
module simd_add
  import simd_add_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                mode_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  output logic [DATA_W-1:0]         sum_o,
  output logic [DATA_W/SEG_W-1:0]   cout_o
);
  localparam int unsigned NSEG = DATA_W / SEG_W;
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned QTR  = DATA_W / 4;

  simd_mode_e        mode;
  logic [NSEG-1:0]   cut;
  logic [NSEG-1:0]   seg_cin;
  logic [NSEG-1:0]   seg_cout;
  logic [DATA_W-1:0] sum_c;

  assign mode = simd_mode_e'(mode_i);

  simd_lane_cut #(.NSEG(NSEG)) u_cut (
    .mode_i(mode),
    .cut_o (cut)
  );

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign seg_cin[k] = 1'b0;
    end else begin : g_chain
      assign seg_cin[k] = seg_cout[k-1] & ~cut[k];
    end

    simd_seg_add #(.W(SEG_W)) u_seg (
      .a_i   (a_i[k*SEG_W +: SEG_W]),
      .b_i   (b_i[k*SEG_W +: SEG_W]),
      .cin_i (seg_cin[k]),
      .sum_o (sum_c[k*SEG_W +: SEG_W]),
      .cout_o(seg_cout[k])
    );
  end

  simd_out_stage #(.W(DATA_W + NSEG), .EN(OUT_REG)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({seg_cout, sum_c}),
    .q_o   ({cout_o, sum_o})
  );

  always_comb begin
    case (mode)
      MODE_W64: begin
        assert_full_add_R2: assert ({seg_cout[NSEG-1], sum_c} == {1'b0, a_i} + {1'b0, b_i})
          else $error("1x64 sum wrong");
      end
      MODE_W32: begin
        assert_half_sum_R3: assert (sum_c[DATA_W-1:HALF] == a_i[DATA_W-1:HALF] + b_i[DATA_W-1:HALF])
          else $error("2x32 upper lane wrong");
        assert_lane_carry_R7: assert ({seg_cout[NSEG/2-1], sum_c[HALF-1:0]} ==
                                      {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]})
          else $error("2x32 lower lane carry wrong");
      end
      MODE_W16: begin
        assert_qtr_sum_R4: assert (sum_c[2*QTR-1:QTR] == a_i[2*QTR-1:QTR] + b_i[2*QTR-1:QTR])
          else $error("4x16 lane 1 wrong");
      end
      default: begin
        assert_byte_sum_R5: assert ({seg_cout[0], sum_c[SEG_W-1:0]} ==
                                    {1'b0, a_i[SEG_W-1:0]} + {1'b0, b_i[SEG_W-1:0]})
          else $error("8x8 byte 0 wrong");
        assert_no_cross_R6: assert (sum_c[2*SEG_W-1:SEG_W] == a_i[2*SEG_W-1:SEG_W] + b_i[2*SEG_W-1:SEG_W])
          else $error("carry leaked into byte 1");
      end
    endcase
  end

  if (OUT_REG) begin : g_reg_chk
    assert_reg_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_W64) |=> (sum_o == $past(a_i + b_i)))
      else $error("registered sum latency wrong");
  end
endmodule

// File: tb/simd_add_tb.sv
`timescale 1ns/1ps
module simd_add_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] sum_o;
  logic [7:0]  cout_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_add u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o),
    .cout_o(cout_o)
  );

  // {mode, a, b, expected sum, expected carry bits (lane tops only)}
  localparam int NV = 10;
  localparam logic [201:0] VEC [NV] = '{
    {2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0, 8'h80},
    {2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0, 8'h88},
    {2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 64'h0, 8'hAA},
    {2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'h0, 8'hFF},
    {2'b00, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 8'h00},
    {2'b01, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0, 8'h08},
    {2'b11, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0, 8'h01},
    {2'b10, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0100, 8'h00},
    {2'b11, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 64'h0, 8'hFF},
    {2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h1234_5678_9ABC_DEF0, 8'h00}
  };

  function automatic logic [7:0] top_mask(input logic [1:0] m);
    case (m)
      2'b00:   return 8'h80;
      2'b01:   return 8'h88;
      2'b10:   return 8'hAA;
      default: return 8'hFF;
    endcase
  endfunction

  // per-lane reference model
  function automatic void ref_add(input logic [1:0] m, input logic [63:0] a, b,
                                  output logic [63:0] s, output logic [7:0] c);
    int lw = 64 >> m;
    int nl = 64 / lw;
    logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
    s = '0;
    c = '0;
    for (int l = 0; l < nl; l++) begin
      logic [64:0] t;
      t = {1'b0, (a >> (l * lw)) & mask} + {1'b0, (b >> (l * lw)) & mask};
      s |= (t[63:0] & mask) << (l * lw);
      c[(l + 1) * lw / 8 - 1] = t[lw];
    end
  endfunction

  task automatic apply(input logic [1:0] m, input logic [63:0] a, b);
    @(negedge clk_i);
    mode_i = m;
    a_i    = a;
    b_i    = b;
    @(negedge clk_i);
  endtask

  task automatic judge(input string tag, input logic [1:0] m,
                       input logic [63:0] es, input logic [7:0] ec);
    checks++;
    if (sum_o !== es || (cout_o & top_mask(m)) !== ec) begin
      fails++;
      $display("FAIL %s mode=%0d sum=%h cout=%h expected sum=%h cout=%h",
               tag, m, sum_o, cout_o & top_mask(m), es, ec);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] es;
    logic [7:0]  ec;

    // R8: reset holds outputs at zero despite live inputs
    mode_i = 2'b11; a_i = '1; b_i = '1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    judge("R8 reset", 2'b11, 64'h0, 8'h00);
    checks++;
    if (cout_o !== 8'h00) begin
      fails++;
      $display("FAIL R8 reset cout=%h expected 00", cout_o);
    end
    mode_i = 2'b00; a_i = '0; b_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8: one-cycle latency
    mode_i = 2'b00; a_i = 64'd5; b_i = 64'd6;
    #1;
    judge("R8 before edge", 2'b00, 64'h0, 8'h00);
    @(negedge clk_i);
    judge("R8 after edge", 2'b00, 64'd11, 8'h00);

    // R1..R7 table
    for (int i = 0; i < NV; i++) begin
      logic [201:0] v;
      v = VEC[i];
      apply(v[201:200], v[199:136], v[135:72]);
      judge("R1 R2 R3 R4 R5 R6 R7 table", v[201:200], v[71:8], v[7:0]);
    end

    // random per mode, plus all-ones corners: R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 120; n++) begin
        logic [63:0] a, b;
        a = {$urandom(), $urandom()};
        b = {$urandom(), $urandom()};
        if (n % 4 == 0) a = '1;
        if (n % 8 == 1) b = '1;
        ref_add(2'(m), a, b, es, ec);
        apply(2'(m), a, b);
        case (m)
          0:       judge("R2 random", 2'(m), es, ec);
          1:       judge("R3 random", 2'(m), es, ec);
          2:       judge("R4 random", 2'(m), es, ec);
          default: judge("R5 random", 2'(m), es, ec);
        endcase
      end
    end

    // R6: overflow of every lane leaves others with own sums
    for (int m = 0; m < 4; m++) begin
      logic [63:0] a, b;
      a = 64'hFFFF_FFFF_FFFF_FFFF;
      b = 64'h0101_0101_0101_0101;
      ref_add(2'(m), a, b, es, ec);
      apply(2'(m), a, b);
      judge("R6 isolation", 2'(m), es, ec);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule